// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Wait-State Acknowledge

This block decodes each bus cycle against a small bank of programmable select entries. Every entry holds two 32-bit words: a base word and a mask word. An entry claims a cycle when three conditions hold. First, the upper 24 address bits and the 4-bit function code agree with the base word in every position the mask leaves significant. Second, the entry is marked valid. Third, the cycle is not a write into a write-protected region. If several entries claim the same cycle, the lowest-numbered entry wins, and it is the only select driven.

Once a cycle is claimed, the winning entry either times the data-transfer acknowledge itself or leaves acknowledge to outside logic. When it times the acknowledge, it holds the select for a programmed number of wait states and then signals the port width on a two-bit size-acknowledge output for a single clock. A fast-termination option shortens that wait by one clock. When acknowledge is external, the select stays asserted until the bus reports the end of the cycle. Configuration words arrive through a simple write port. A start strobe carries the address, the function code and the read/write direction of each new cycle.

Top module: `csel_bank`

## Requirements
- R1: After reset, `cs_o` and `size_ack` are zero and every entry is invalid, so a cycle start asserts no select.
- R2: A pulse on `cfg_we` writes `cfg_wdata` into entry `cfg_idx`. When `cfg_sel`=0 the base word is written, and when `cfg_sel`=1 the mask word is written.
- R3: Address bits 31..8 are compared with base bits 31..8 wherever mask bits 31..8 are 0. A mask bit of 1 makes that address bit don't-care. Address bits 7..0 never affect matching.
- R4: The function code `cyc_fc` is compared with base bits 7..4 wherever mask bits 7..4 are 0. A mask bit of 1 makes that code bit don't-care.
- R5: An entry whose base bit 0 is 0 never matches.
- R6: When base bit 3 is 1, write cycles (`cyc_rd`=0) never match the entry, while read cycles still can.
- R7: When several entries match, only the lowest-numbered one is asserted on `cs_o`, and it alone sets the acknowledge behaviour.
- R8: Mask bits 1..0 choose the acknowledge. A value of 01 gives `size_ack`=01 (16-bit port). A value of 10 gives `size_ack`=10 (8-bit port). Values 11 and 00 leave acknowledge external: `size_ack` stays 00 and the select is held until `cyc_end`.
- R9: With internal acknowledge and mask bits 3..2 = n, `size_ack` is non-zero for exactly one clock, n+1 clocks after the edge that accepts the start. The select is asserted from the accepting edge through the acknowledge clock, and it drops on the clock after the acknowledge.
- R10: Base bit 2 (fast termination) reduces the wait count by one, with a floor of zero: n=3 acknowledges 3 clocks after the start, and n=0 acknowledges 1 clock after it.
- R11: A start strobe that arrives while a cycle is still in progress is ignored. The current select is unchanged.
- R12: A cycle that matches no entry asserts no select and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (2) | Entry number being written |
| cfg_sel | input | 1 | 0 selects the base word, 1 selects the mask word |
| cfg_wdata | input | 32 | Configuration word |
| cyc_start | input | 1 | One-clock strobe that begins a bus cycle |
| cyc_addr | input | 32 | Cycle address, valid with `cyc_start` |
| cyc_fc | input | 4 | Cycle function code, valid with `cyc_start` |
| cyc_rd | input | 1 | 1 for a read cycle, 0 for a write cycle |
| cyc_end | input | 1 | End of an externally acknowledged cycle |
| cs_o | output | N_SEL (4) | One-hot chip selects, active high |
| size_ack | output | 2 | Port-size acknowledge: 01 means 16-bit, 10 means 8-bit, 00 means none |

## Verification
The assertions assume that `cyc_start` is a single-clock strobe with its address, code and direction stable in that clock. They also assume that `cyc_end` is raised only for cycles acknowledged externally and that configuration is not rewritten while a cycle is open. The directed stimulus respects these assumptions. It changes inputs only on the falling edge, pulses each strobe for exactly one clock, and rewrites an entry only after the previous select has dropped. The one intentional violation is a start issued during an open external cycle, which exercises the rule that such a start is ignored.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int REG_W = 32;
  localparam int AHI_W = 24;
  localparam int FC_W  = 4;
  localparam int WS_W  = 2;

  typedef struct packed {
    logic [AHI_W-1:0] addr;
    logic [FC_W-1:0]  fc;
    logic             wprot;
    logic             fast;
    logic             spare;
    logic             valid;
  } base_t;

  typedef struct packed {
    logic [AHI_W-1:0] addr_dc;
    logic [FC_W-1:0]  fc_dc;
    logic [WS_W-1:0]  waits;
    logic [1:0]       kind;
  } mask_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_EXT  = 2'd3
  } cyc_state_e;

  // Entry hit: address and code agree where not masked, entry live, no protected write.
  function automatic logic entry_hit(input base_t b, input mask_t m,
                                     input logic [REG_W-1:0] addr,
                                     input logic [FC_W-1:0] fc,
                                     input logic rd);
    logic addr_ok, fc_ok;
    addr_ok = ((addr[REG_W-1:REG_W-AHI_W] ^ b.addr) & ~m.addr_dc) == '0;
    fc_ok   = ((fc ^ b.fc) & ~m.fc_dc) == '0;
    return b.valid && addr_ok && fc_ok && !(b.wprot && !rd);
  endfunction

  // Effective wait count after optional fast termination (floor zero).
  function automatic logic [WS_W-1:0] eff_wait(input logic [WS_W-1:0] n,
                                               input logic fast);
    if (!fast)     return n;
    if (n == '0)   return '0;
    return n - 1'b1;
  endfunction

  // Acknowledge generated inside the block only for the two port-size codes.
  function automatic logic ack_inside(input logic [1:0] kind);
    return (kind == 2'b01) || (kind == 2'b10);
  endfunction

endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int N_SEL = 4,
  localparam int IDX_W = $clog2(N_SEL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic                   cfg_sel,
  input  logic [REG_W-1:0]       cfg_wdata,
  output base_t [N_SEL-1:0]      base_q,
  output mask_t [N_SEL-1:0]      mask_q
);

  for (genvar g = 0; g < N_SEL; g++) begin : g_ent
    logic wr_here;
    assign wr_here = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        mask_q[g] <= '0;
      end else if (wr_here) begin
        if (cfg_sel) mask_q[g] <= mask_t'(cfg_wdata);
        else         base_q[g] <= base_t'(cfg_wdata);
      end
    end
  end

endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int N_SEL = 4
) (
  input  base_t [N_SEL-1:0] base_q,
  input  mask_t [N_SEL-1:0] mask_q,
  input  logic [REG_W-1:0]  cyc_addr,
  input  logic [FC_W-1:0]   cyc_fc,
  input  logic              cyc_rd,
  output logic [N_SEL-1:0]  hit
);

  for (genvar g = 0; g < N_SEL; g++) begin : g_cmp
    assign hit[g] = entry_hit(base_q[g], mask_q[g], cyc_addr, cyc_fc, cyc_rd);
  end

endmodule

// File: rtl/csel_prio.sv
module csel_prio
  import csel_pkg::*;
#(
  parameter int N_SEL = 4,
  localparam int IDX_W = $clog2(N_SEL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SEL-1:0] hit,
  output logic [N_SEL-1:0] grant,
  output logic [IDX_W-1:0] win_idx,
  output logic             any_hit
);

  always_comb begin
    grant   = '0;
    win_idx = '0;
    any_hit = 1'b0;
    for (int i = 0; i < N_SEL; i++) begin
      if (hit[i] && !any_hit) begin
        grant[i] = 1'b1;
        win_idx  = IDX_W'(i);
        any_hit  = 1'b1;
      end
    end
  end

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & (grant - 1'b1)) == '0);  // R7

  AST_GRANT_IN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~hit) == '0 && ((hit != '0) == (grant != '0)));  // R7

endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
  import csel_pkg::*;
#(
  parameter int N_SEL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             cyc_end,
  input  logic [N_SEL-1:0] grant,
  input  logic             any_hit,
  input  logic [WS_W-1:0]  wait_cnt,
  input  logic [1:0]       kind,
  output logic             start_acc,
  output logic [N_SEL-1:0] cs_o,
  output logic [1:0]       size_ack
);

  cyc_state_e       state;
  logic [WS_W-1:0]  cnt;
  logic [N_SEL-1:0] cs_q;
  logic [1:0]       size_q;
  logic             idle;
  logic             wait_done;

  assign idle      = (state == ST_IDLE);
  assign start_acc = cyc_start && idle && any_hit;
  assign wait_done = (state == ST_WAIT) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cs_q   <= '0;
      size_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_acc) begin
          cs_q   <= grant;
          size_q <= kind;
          cnt    <= wait_cnt;
          state  <= ack_inside(kind) ? ST_WAIT : ST_EXT;
        end
        ST_WAIT: begin
          if (wait_done) state <= ST_ACK;
          else           cnt   <= cnt - 1'b1;
        end
        ST_ACK: begin
          state <= ST_IDLE;
          cs_q  <= '0;
        end
        ST_EXT: if (cyc_end) begin
          state <= ST_IDLE;
          cs_q  <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_o     = cs_q;
  assign size_ack = (state == ST_ACK) ? size_q : 2'b00;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (size_ack != 2'b00) |=> (size_ack == 2'b00));  // R9

  AST_ACK_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (size_ack != 2'b00) |-> (cs_o != '0));  // R9

  AST_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (size_ack != 2'b00) |=> (cs_o == '0));  // R9

  AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|cs_o) |-> (size_ack == 2'b00));  // R9

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_o != '0) && (size_ack == 2'b00) && !cyc_end) |=> $stable(cs_o));  // R11

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));  // R7

endmodule

// File: rtl/csel_bank.sv
module csel_bank
  import csel_pkg::*;
#(
  parameter int N_SEL = 4,
  localparam int IDX_W = $clog2(N_SEL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             cyc_start,
  input  logic [31:0]      cyc_addr,
  input  logic [3:0]       cyc_fc,
  input  logic             cyc_rd,
  input  logic             cyc_end,
  output logic [N_SEL-1:0] cs_o,
  output logic [1:0]       size_ack
);

  base_t [N_SEL-1:0] base_q;
  mask_t [N_SEL-1:0] mask_q;
  logic  [N_SEL-1:0] hit;
  logic  [N_SEL-1:0] grant;
  logic  [IDX_W-1:0] win_idx;
  logic              any_hit;
  logic              start_acc;
  base_t             win_base;
  mask_t             win_mask;
  logic  [WS_W-1:0]  win_wait;

  csel_regs #(.N_SEL(N_SEL)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_q(base_q), .mask_q(mask_q)
  );

  csel_match #(.N_SEL(N_SEL)) u_match (
    .base_q(base_q), .mask_q(mask_q), .cyc_addr(cyc_addr),
    .cyc_fc(cyc_fc), .cyc_rd(cyc_rd), .hit(hit)
  );

  csel_prio #(.N_SEL(N_SEL)) u_prio (
    .clk(clk), .rst_n(rst_n), .hit(hit), .grant(grant),
    .win_idx(win_idx), .any_hit(any_hit)
  );

  assign win_base = base_q[win_idx];
  assign win_mask = mask_q[win_idx];
  assign win_wait = eff_wait(win_mask.waits, win_base.fast);

  csel_ctrl #(.N_SEL(N_SEL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .grant(grant), .any_hit(any_hit), .wait_cnt(win_wait),
    .kind(win_mask.kind), .start_acc(start_acc),
    .cs_o(cs_o), .size_ack(size_ack)
  );

  AST_START_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (cs_o != '0));  // R12

  AST_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && !cyc_rd) |-> !win_base.wprot);  // R6

endmodule

// File: tb/sim_csel_bank.sv
module sim_csel_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cyc_start = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [3:0]  cyc_fc = '0;
  logic        cyc_rd = 1'b1;
  logic        cyc_end = 1'b0;
  logic [3:0]  cs_o;
  logic [1:0]  size_ack;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_bank u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cyc_start(cyc_start),
    .cyc_addr(cyc_addr), .cyc_fc(cyc_fc), .cyc_rd(cyc_rd),
    .cyc_end(cyc_end), .cs_o(cs_o), .size_ack(size_ack)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] idx, input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_cyc(input logic [31:0] a, input logic [3:0] fc, input logic rd);
    @(negedge clk);
    cyc_start = 1'b1; cyc_addr = a; cyc_fc = fc; cyc_rd = rd;
    @(negedge clk);
    cyc_start = 1'b0;
  endtask

  // Internally acknowledged cycle: select, size, latency, single pulse, release.
  task automatic run_int(input logic [31:0] a, input logic [3:0] fc, input logic rd,
                         input logic [3:0] exp_cs, input logic [1:0] exp_size,
                         input int exp_lat, input string tag);
    int lat;
    start_cyc(a, fc, rd);
    chk(cs_o == exp_cs, {tag, " select"}, 32'(cs_o), 32'(exp_cs));
    lat = 0;
    while (size_ack == 2'b00 && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    chk(size_ack == exp_size, {tag, " size"}, 32'(size_ack), 32'(exp_size));
    chk(lat == exp_lat, {tag, " latency"}, 32'(lat), 32'(exp_lat));
    chk(cs_o == exp_cs, {tag, " select at ack"}, 32'(cs_o), 32'(exp_cs));
    @(negedge clk);
    chk(size_ack == 2'b00 && cs_o == 4'b0000, {tag, " release"},
        {26'd0, size_ack, cs_o}, 32'd0);
  endtask

  task automatic run_miss(input logic [31:0] a, input logic [3:0] fc, input logic rd,
                          input string tag);
    bit ok;
    start_cyc(a, fc, rd);
    ok = (cs_o == 4'b0000) && (size_ack == 2'b00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ok &= (cs_o == 4'b0000) && (size_ack == 2'b00);
    end
    chk(ok, {tag, " no select"}, {26'd0, size_ack, cs_o}, 32'd0);
  endtask

  task automatic run_ext(input logic [31:0] a, input logic [3:0] fc,
                         input logic [3:0] exp_cs, input bit intrude, input string tag);
    bit ok;
    start_cyc(a, fc, 1'b1);
    ok = (cs_o == exp_cs) && (size_ack == 2'b00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ok &= (cs_o == exp_cs) && (size_ack == 2'b00);
    end
    chk(ok, {tag, " held without ack"}, {26'd0, size_ack, cs_o}, 32'(exp_cs));
    if (intrude) begin
      start_cyc(32'h3000_0000, 4'h0, 1'b1);
      @(negedge clk);
      chk(cs_o == exp_cs && size_ack == 2'b00, {tag, " R11 start ignored"},
          {26'd0, size_ack, cs_o}, 32'(exp_cs));
    end
    @(negedge clk);
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
    chk(cs_o == 4'b0000, {tag, " released by end"}, 32'(cs_o), 32'd0);
  endtask

  task automatic t_reset();
    chk(cs_o == 4'b0000 && size_ack == 2'b00, "R1 reset outputs",
        {26'd0, size_ack, cs_o}, 32'd0);
    run_miss(32'h0000_0000, 4'h0, 1'b1, "R1 R5 no entry after reset");
  endtask

  task automatic t_addr_fc();
    // entry0: upper byte 0x10, code 5, 2 waits, 16-bit port
    cfg_write(2'd0, 1'b0, 32'h1000_0051);
    cfg_write(2'd0, 1'b1, 32'h00FF_FF09);
    run_int(32'h1012_34AB, 4'h5, 1'b1, 4'b0001, 2'b01, 3, "R2 R3 R8 R9 entry0 hit");
    run_miss(32'h1100_0000, 4'h5, 1'b1, "R3 R12 address miss");
    run_miss(32'h1000_0000, 4'h6, 1'b1, "R4 code miss");
  endtask

  task automatic t_fc_mask_wprot();
    // entry1: upper 0x200000, code 2 with bit0 don't-care, protected, no waits, 8-bit
    cfg_write(2'd1, 1'b0, 32'h2000_0029);
    cfg_write(2'd1, 1'b1, 32'h0000_0012);
    run_int(32'h2000_00FF, 4'h3, 1'b1, 4'b0010, 2'b10, 1, "R4 R8 masked code byte port");
    run_miss(32'h2000_0000, 4'h6, 1'b1, "R4 unmasked code bit differs");
    run_miss(32'h2000_0000, 4'h2, 1'b0, "R6 protected write");
  endtask

  task automatic t_fast();
    // entry2: upper 0x300000, any code, fast termination, 3 waits, 16-bit
    cfg_write(2'd2, 1'b0, 32'h3000_0005);
    cfg_write(2'd2, 1'b1, 32'h0000_00FD);
    run_int(32'h3000_0010, 4'h7, 1'b0, 4'b0100, 2'b01, 3, "R10 fast with 3 waits");
    cfg_write(2'd2, 1'b1, 32'h0000_00F1);
    run_int(32'h3000_0010, 4'h7, 1'b0, 4'b0100, 2'b01, 1, "R10 fast floor zero");
  endtask

  task automatic t_valid();
    cfg_write(2'd0, 1'b0, 32'h1000_0050);
    run_miss(32'h1012_34AB, 4'h5, 1'b1, "R5 invalid entry");
  endtask

  task automatic t_priority();
    // entry3: matches everything, 1 wait, 8-bit
    cfg_write(2'd3, 1'b0, 32'h0000_0001);
    cfg_write(2'd3, 1'b1, 32'hFFFF_FFF6);
    run_int(32'h3000_0000, 4'h0, 1'b1, 4'b0100, 2'b01, 1, "R7 lowest index wins");
    run_int(32'h5000_0000, 4'h9, 1'b1, 4'b1000, 2'b10, 2, "R7 R9 catch-all one wait");
  endtask

  task automatic t_external();
    cfg_write(2'd3, 1'b1, 32'hFFFF_FFF3);
    run_ext(32'h5000_0000, 4'h1, 4'b1000, 1'b1, "R8 code 11 external");
    cfg_write(2'd3, 1'b1, 32'hFFFF_FFF0);
    run_ext(32'h6000_0000, 4'h2, 4'b1000, 1'b0, "R8 code 00 external");
    run_int(32'h3000_0000, 4'h0, 1'b1, 4'b0100, 2'b01, 1, "R11 idle again");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_fc();
    t_fc_mask_wprot();
    t_fast();
    t_valid();
    t_priority();
    t_external();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule